// File: doc/BRIEF.md
# Two-PLL Lock Sequencer

This block orders the acquisition of a clock-recovery front end built from a crystal oscillator, a frequency-synthesis PLL and a data-recovery PLL. It walks through five wait steps: oscillator stable, synthesis PLL locked, recovery PLL frequency-locked, data activity seen, and recovery PLL phase-locked. It then holds a locked state. Each step enables the next piece of the front end and waits for that piece's status input.

After the first power-on pass, the oscillator and the synthesis PLL are left running. An active-low restart input that stays low long enough sends the sequence back to frequency acquisition. A loss of phase lock drops the locked flag and returns the sequence to waiting for data activity.

Every wait step has a cycle-count timeout. When a timeout expires, a per-step sticky error bit is set and the same step is retried. The current step is brought out as a one-hot vector for observation.

Top module: `lock_seq_ctrl`

## Requirements
- R1: After `rst_n` is asserted, the block is in the oscillator wait step: `state_oh` = 6'b000001, `syn_en`, `rec_en`, `act_en` and `locked` are low, and `err_sticky` is 0.
- R2: The block leaves each wait step only on the rising clock edge that samples that step's own status input high, and it advances exactly one step per edge. The steps and their status inputs are, in order: oscillator (`osc_ok`), synthesis lock (`syn_lock`), frequency lock (`rec_flock`), data activity (`data_act`), phase lock (`rec_plock`). Status inputs that belong to later steps have no effect.
- R3: `syn_en` is high in every step after the oscillator step. `rec_en` is high from the frequency-lock step onward. `act_en` is high from the data-activity step onward.
- R4: `locked` rises only on the edge after the phase-lock step samples `rec_plock` high. `state_oh` bit 5 marks the locked state.
- R5: In the locked state, an edge that samples `rec_plock` low moves the block to the data-activity step (`state_oh` bit 3), and `locked` falls on that same edge.
- R6: When `restart_n` is sampled low on RESTART_CYC consecutive edges (50 ns at the clock period, 3 edges at 20 ns), and the block is in the frequency-lock step or any later step, the block enters the frequency-lock step (`state_oh` bit 2) on the edge of the last of those samples. `syn_en` stays high. Restart takes priority over any status input.
- R7: A low pulse on `restart_n` that is sampled on fewer than RESTART_CYC consecutive edges has no effect.
- R8: A restart that qualifies while the block is in the oscillator step or the synthesis step is ignored.
- R9: When the block has stayed TIMEOUT_CYC edges in a wait step without leaving it, the error bit for that step is set on the TIMEOUT_CYC-th edge. The bits are: 0 oscillator, 1 synthesis, 2 frequency, 3 activity, 4 phase. The step is then retried with a fresh count. If the step advances on that same edge, no error is recorded.
- R10: Bits of `err_sticky` never clear except through `rst_n`.
- R11: `state_oh` always has exactly one bit set. Bits 0 to 5 are the oscillator, synthesis, frequency, activity, phase and locked states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, returns to the oscillator step |
| osc_ok | input | 1 | Oscillator stable status |
| syn_lock | input | 1 | Synthesis PLL locked status |
| rec_flock | input | 1 | Recovery PLL frequency-locked status |
| data_act | input | 1 | Activity detected on the incoming data line |
| rec_plock | input | 1 | Recovery PLL phase-locked status |
| restart_n | input | 1 | Active-low restart request, width-qualified |
| syn_en | output | 1 | Synthesis PLL enable |
| rec_en | output | 1 | Recovery PLL enable |
| act_en | output | 1 | Activity detector enable |
| locked | output | 1 | Whole front end locked |
| state_oh | output | 6 | One-hot current step |
| err_sticky | output | 5 | Sticky per-step timeout flags |

## Verification
Every output comes straight from a state register, so the effect of a status input is due on the first rising edge that samples it. A qualified restart lands on the edge of its third low sample, and a timeout error appears on the fortieth edge spent in a step. The driver changes inputs at the falling edge and queues exactly one expected item per clock. The monitor pops that item 1 ns after the next rising edge. Each expectation is therefore tied to the single edge that must produce it. Timeout runs are written as 39 quiet cycles followed by the deciding one, so that both an early error and a late error are caught.

// File: rtl/lkseq_pkg.sv
package lkseq_pkg;

  typedef enum logic [2:0] {
    ST_OSC = 3'd0,
    ST_SYN = 3'd1,
    ST_FRQ = 3'd2,
    ST_ACT = 3'd3,
    ST_PHS = 3'd4,
    ST_LCK = 3'd5
  } step_e;

  localparam int NSTATE = 6;
  localparam int NWAIT  = 5;

  // Minimum pulse width in ns turned into whole clock samples, rounded up.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic logic [NSTATE-1:0] onehot_of(step_e s);
    return NSTATE'(1) << s;
  endfunction

  // Steps reachable by a restart (frequency acquisition and beyond).
  function automatic logic is_late(step_e s);
    return (s == ST_FRQ) || (s == ST_ACT) || (s == ST_PHS) || (s == ST_LCK);
  endfunction

endpackage

// File: rtl/lkseq_restart_filter.sv
module lkseq_restart_filter #(
  parameter int unsigned MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_n,
  output logic fire
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] low_cnt;

  // One pulse per low period, on the edge taking the MIN_CYC-th low sample.
  assign fire = !restart_n && (low_cnt == CW'(MIN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (restart_n) begin
      low_cnt <= '0;
    end else if (low_cnt < CW'(MIN_CYC)) begin
      low_cnt <= low_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/lkseq_wait_timer.sv
module lkseq_wait_timer #(
  parameter int unsigned LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign expired = arm && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || expired || !arm) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/lkseq_fsm.sv
module lkseq_fsm
  import lkseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_ok,
  input  logic             syn_lock,
  input  logic             rec_flock,
  input  logic             data_act,
  input  logic             rec_plock,
  input  logic             restart_fire,
  input  logic             timeout,
  output step_e            state,
  output logic             leave,
  output logic             restart_taken,
  output logic [NWAIT-1:0] err
);
  step_e nxt;

  assign restart_taken = restart_fire && is_late(state);

  always_comb begin
    nxt = state;
    if (restart_taken) begin
      nxt = ST_FRQ;
    end else begin
      unique case (state)
        ST_OSC:  if (osc_ok)     nxt = ST_SYN;
        ST_SYN:  if (syn_lock)   nxt = ST_FRQ;
        ST_FRQ:  if (rec_flock)  nxt = ST_ACT;
        ST_ACT:  if (data_act)   nxt = ST_PHS;
        ST_PHS:  if (rec_plock)  nxt = ST_LCK;
        ST_LCK:  if (!rec_plock) nxt = ST_ACT;
        default: nxt = ST_OSC;
      endcase
    end
  end

  assign leave = (nxt != state);

  logic            tmo_hit;
  logic [NWAIT-1:0] tmo_bit;

  assign tmo_hit = timeout && !leave && !restart_taken;
  assign tmo_bit = NWAIT'(1) << state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OSC;
      err   <= '0;
    end else begin
      state <= nxt;
      if (tmo_hit) err <= err | tmo_bit;
    end
  end
endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import lkseq_pkg::*;
#(
  parameter int unsigned CLK_NS         = 20,
  parameter int unsigned RESTART_MIN_NS = 50,
  parameter int unsigned TIMEOUT_CYC    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_ok,
  input  logic              syn_lock,
  input  logic              rec_flock,
  input  logic              data_act,
  input  logic              rec_plock,
  input  logic              restart_n,
  output logic              syn_en,
  output logic              rec_en,
  output logic              act_en,
  output logic              locked,
  output logic [NSTATE-1:0] state_oh,
  output logic [NWAIT-1:0]  err_sticky
);
  localparam int unsigned RESTART_CYC = ns_to_cyc(RESTART_MIN_NS, CLK_NS);

  logic  restart_fire;
  logic  timeout;
  logic  leave;
  logic  restart_taken;
  step_e state;

  lkseq_restart_filter #(.MIN_CYC(RESTART_CYC)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_n (restart_n),
    .fire      (restart_fire)
  );

  lkseq_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (leave || restart_taken),
    .arm     (state != ST_LCK),
    .expired (timeout)
  );

  lkseq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .osc_ok        (osc_ok),
    .syn_lock      (syn_lock),
    .rec_flock     (rec_flock),
    .data_act      (data_act),
    .rec_plock     (rec_plock),
    .restart_fire  (restart_fire),
    .timeout       (timeout),
    .state         (state),
    .leave         (leave),
    .restart_taken (restart_taken),
    .err           (err_sticky)
  );

  assign state_oh = onehot_of(state);
  assign syn_en   = (state != ST_OSC);
  assign rec_en   = is_late(state);
  assign act_en   = (state == ST_ACT) || (state == ST_PHS) || (state == ST_LCK);
  assign locked   = (state == ST_LCK);
endmodule

// File: rtl/lkseq_checker.sv
module lkseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] state_oh,
  input logic       locked,
  input logic       syn_en,
  input logic       rec_plock,
  input logic       restart_fire,
  input logic [4:0] err
);
  // R11
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);

  // R4
  a_r4_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(state_oh[4]) && $past(rec_plock)));

  // R5
  a_r5_loss_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rec_plock && !restart_fire) |=> (state_oh[3] && !locked));

  // R6
  a_r6_restart_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_fire && (state_oh[5:2] != 4'b0)) |=> (state_oh[2] && syn_en));

  // R10
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err & $past(err)) == $past(err)));
endmodule

bind lock_seq_ctrl lkseq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_oh     (state_oh),
  .locked       (locked),
  .syn_en       (syn_en),
  .rec_plock    (rec_plock),
  .restart_fire (restart_fire),
  .err          (err_sticky)
);

// File: tb/lock_seq_ctrl_bench.sv
module lock_seq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n, osc_ok, syn_lock, rec_flock, data_act, rec_plock, restart_n;
  logic syn_en, rec_en, act_en, locked;
  logic [5:0] state_oh;
  logic [4:0] err_sticky;

  localparam logic [5:0] E_OSC = 6'b000001;
  localparam logic [5:0] E_SYN = 6'b000010;
  localparam logic [5:0] E_FRQ = 6'b000100;
  localparam logic [5:0] E_ACT = 6'b001000;
  localparam logic [5:0] E_PHS = 6'b010000;
  localparam logic [5:0] E_LCK = 6'b100000;

  always #10 clk = ~clk;

  lock_seq_ctrl u_lock_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_ok(osc_ok), .syn_lock(syn_lock),
    .rec_flock(rec_flock), .data_act(data_act), .rec_plock(rec_plock),
    .restart_n(restart_n), .syn_en(syn_en), .rec_en(rec_en),
    .act_en(act_en), .locked(locked), .state_oh(state_oh),
    .err_sticky(err_sticky)
  );

  int checks = 0;
  int fails  = 0;

  logic [5:0] q_st[$];
  logic [4:0] q_er[$];
  string      q_tag[$];

  // Driver: inputs already set at a falling edge; expect after next rise.
  task automatic tick(input logic [5:0] es, input logic [4:0] ee, input string tag);
    q_st.push_back(es);
    q_er.push_back(ee);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: scoreboard comparison 1 ns after each rising edge.
  always begin
    @(posedge clk);
    #1;
    if (q_st.size() > 0) begin
      logic [5:0] es;
      logic [4:0] ee;
      logic [3:0] eo, ao;
      string      tg;
      es = q_st.pop_front();
      ee = q_er.pop_front();
      tg = q_tag.pop_front();
      eo = {|es[5:1], |es[5:2], |es[5:3], es[5]};
      ao = {syn_en, rec_en, act_en, locked};
      checks++;
      if (state_oh !== es) begin
        fails++;
        $display("FAIL %s state_oh actual=%b expected=%b", tg, state_oh, es);
      end
      checks++;
      if (err_sticky !== ee) begin
        fails++;
        $display("FAIL %s err_sticky actual=%b expected=%b", tg, err_sticky, ee);
      end
      checks++;
      if (ao !== eo) begin
        fails++;
        $display("FAIL R3 (%s) syn/rec/act/locked actual=%b expected=%b", tg, ao, eo);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; osc_ok = 1'b0; syn_lock = 1'b0; rec_flock = 1'b0;
    data_act = 1'b0; rec_plock = 1'b0; restart_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(E_OSC, 5'h0, "R1 reset state");

    // R2: later status inputs have no effect in step 1
    syn_lock = 1'b1; rec_flock = 1'b1; data_act = 1'b1; rec_plock = 1'b1;
    tick(E_OSC, 5'h0, "R2 later status ignored");
    syn_lock = 1'b0; rec_flock = 1'b0; data_act = 1'b0; rec_plock = 1'b0;

    // R8: qualified restart in oscillator step ignored
    restart_n = 1'b0;
    repeat (4) tick(E_OSC, 5'h0, "R8 restart in osc step");
    restart_n = 1'b1;

    osc_ok = 1'b1;
    tick(E_SYN, 5'h0, "R2 osc -> syn");

    // R8: qualified restart in synthesis step ignored
    restart_n = 1'b0;
    repeat (3) tick(E_SYN, 5'h0, "R8 restart in syn step");
    restart_n = 1'b1;
    tick(E_SYN, 5'h0, "R8 after restart");

    syn_lock = 1'b1;  tick(E_FRQ, 5'h0, "R2 syn -> frq");
    rec_flock = 1'b1; tick(E_ACT, 5'h0, "R2 frq -> act");
    data_act = 1'b1;  tick(E_PHS, 5'h0, "R2 act -> phs");
    rec_plock = 1'b1; tick(E_LCK, 5'h0, "R4 phase lock -> locked");
    tick(E_LCK, 5'h0, "R4 hold locked");

    // R7: short restart pulse ignored
    restart_n = 1'b0;
    tick(E_LCK, 5'h0, "R7 short pulse 1");
    tick(E_LCK, 5'h0, "R7 short pulse 2");
    restart_n = 1'b1;
    tick(E_LCK, 5'h0, "R7 short pulse ignored");

    // R6: qualified restart goes to frequency step, priority over status
    restart_n = 1'b0;
    tick(E_LCK, 5'h0, "R6 low sample 1");
    tick(E_LCK, 5'h0, "R6 low sample 2");
    tick(E_FRQ, 5'h0, "R6 restart to freq step");
    restart_n = 1'b1;
    rec_flock = 1'b0; data_act = 1'b0; rec_plock = 1'b0;
    tick(E_FRQ, 5'h0, "R6 waits in freq step");

    rec_flock = 1'b1; tick(E_ACT, 5'h0, "R2 reacquire act");
    data_act = 1'b1;  tick(E_PHS, 5'h0, "R2 reacquire phs");
    rec_plock = 1'b1; tick(E_LCK, 5'h0, "R4 relock");

    // R5: loss of phase lock
    rec_plock = 1'b0; data_act = 1'b0;
    tick(E_ACT, 5'h0, "R5 loss of lock -> act");

    // R9: timeout in activity step
    for (int i = 0; i < 39; i++) tick(E_ACT, 5'h0, "R9 before timeout");
    tick(E_ACT, 5'b01000, "R9 timeout sets activity bit");
    for (int i = 0; i < 40; i++) tick(E_ACT, 5'b01000, "R9 retry keeps bit");

    // R10: bit survives advancing
    data_act = 1'b1;
    tick(E_PHS, 5'b01000, "R10 sticky after advance");

    // R9 boundary: advance on the expiring edge records no error
    for (int i = 0; i < 39; i++) tick(E_PHS, 5'b01000, "R9 phase wait");
    rec_plock = 1'b1;
    tick(E_LCK, 5'b01000, "R9 advance on expiry edge");

    // R10 / R1: only reset clears
    rst_n = 1'b0;
    osc_ok = 1'b0; syn_lock = 1'b0; rec_flock = 1'b0; data_act = 1'b0; rec_plock = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tick(E_OSC, 5'h0, "R10 reset clears errors");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule